// File: doc/BRIEF.md
# DDR2 Auto-Refresh Scheduler

This block produces the periodic refresh traffic of a DDR2 SDRAM controller. A free-running interval timer measures the average refresh period. It shortens that period to half when the high-temperature input is set. Each expiry adds one refresh to a pending count, and a nonzero count raises a request towards the main command scheduler.

Once the scheduler grants, the block takes over the command bus. If any bank is open, it first closes all banks with a precharge (A10 high). It then waits the precharge recovery time and issues REFRESH. After that it keeps the bus blocked for the refresh cycle time. While the grant stays high and refreshes are still owed, the next REFRESH follows directly, one refresh cycle time later.

The pending count can defer refreshes while the scheduler is busy. When the count reaches its limit, the block flags urgency and starts the sequence without waiting for a grant. All timing values are parameters in picoseconds, converted to clock cycles from the clock period.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: While rst_ni is low, the command bus shows NOP ({ras_n,cas_n,we_n} = 3'b111), a10_o is 0, cke_o is 1, and req_o, urgent_o and busy_o are 0.
- R2: With hot_i low, the pending count rises by one every REFI cycles, where REFI = TREFI_PS / TCK_PS. The first increment lands on the REFI-th rising edge after reset release, and req_o is high whenever the count is nonzero.
- R3: With hot_i high, the interval is REFI/2 cycles.
- R4: The pending count saturates at MAX_PEND. urgent_o is high exactly when the count equals MAX_PEND, and an urgent count in idle starts the sequence on the next edge with no grant.
- R5: A sequence starts from idle on the edge after req_o and grant_i (or urgent_o) are seen together. It begins with PRE (3'b010) with a10_o high when banks_open_i is high, and directly with REF (3'b001) otherwise.
- R6: REF follows a PRE exactly RP cycles later, where RP = ceil(TRP_PS / TCK_PS), minimum 2.
- R7: busy_o is high from the first command of a sequence until RFC cycles after its last REF, where RFC = ceil(TRFC_PS / TCK_PS), minimum 2. busy_o falls on the RFC-th edge after that REF.
- R8: If a refresh is still pending and grant_i (or urgent_o) is high when tRFC ends, another REF is issued exactly RFC cycles after the previous one, with no PRE between.
- R9: Each REF reduces the pending count by one, and req_o falls once no refresh remains owed.
- R10: Every cycle that carries neither PRE nor REF carries NOP with a10_o low, and cke_o is high on every cycle.
- R11: grant_i has no effect while req_o is low: the command bus stays at NOP and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hot_i | input | 1 | High case temperature; halves the refresh interval |
| banks_open_i | input | 1 | At least one bank is active |
| grant_i | input | 1 | Main scheduler hands the command bus to refresh |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Pending count at its limit; sequence is forced |
| busy_o | output | 1 | Refresh owns the command bus; no ACT allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10; high selects all banks on PRE |
| cke_o | output | 1 | Clock enable, held high |

## Verification
The bench builds the block with a 4000 ps clock, a 160000 ps interval, 12000 ps tRP and 40000 ps tRFC, and a limit of 8 pending refreshes. That gives a 40-cycle interval (20 when hot), RP = 3 and RFC = 10. With these values the saturation point is reached after 320 cycles, so the forced-start path is exercised directly. Short intervals against tRFC also let back-to-back refreshes and ticks that arrive during a sequence occur often in the random phase, where hot_i, grant_i and banks_open_i change freely.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WRP,
    ST_REF,
    ST_WRFC
  } rs_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = 3'b111;
  localparam ddr_cmd_t CMD_PRE = 3'b010;
  localparam ddr_cmd_t CMD_REF = 3'b001;

endpackage

// File: rtl/refsched_tick.sv
module refsched_tick #(
  parameter int LIM_NORM = 3125,
  parameter int LIM_HOT  = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  output logic tick_o
);
  localparam int CW = $clog2(LIM_NORM + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          wrap;

  assign lim    = hot_i ? CW'(LIM_HOT) : CW'(LIM_NORM);
  // >= so a switch to the short interval with a high count wraps at once
  assign wrap   = (cnt_q >= lim - CW'(1));
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIM_NORM));
  a_r3_hot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_i && $past(hot_i)) |-> cnt_q < CW'(LIM_HOT));

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ref_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q;
  logic          up, dn;

  assign up = tick_i && ((pend_q != PW'(MAX_PEND)) || ref_i);
  assign dn = ref_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + PW'(up) - PW'(dn);
  end

  assign pending_o = (pend_q != '0);
  assign urgent_o  = (pend_q == PW'(MAX_PEND));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(MAX_PEND));
  a_r9_ref_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && !tick_i && pend_q != '0) |=> pend_q == $past(pend_q) - PW'(1));
  a_r2_tick_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ref_i && pend_q != PW'(MAX_PEND)) |=> pend_q == $past(pend_q) + PW'(1));

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import refsched_pkg::*;
#(
  parameter int T_RP  = 6,
  parameter int T_RFC = 30
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pending_i,
  input  logic     urgent_i,
  input  logic     grant_i,
  input  logic     banks_open_i,
  output ddr_cmd_t cmd_o,
  output logic     a10_o,
  output logic     busy_o,
  output logic     ref_o
);
  localparam int T_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WCW   = $clog2(T_MAX + 1);

  rs_state_e      st_q, st_d;
  logic [WCW-1:0] wcnt_q;
  logic           go, wdone;

  assign go    = pending_i && (grant_i || urgent_i);
  assign wdone = (wcnt_q == WCW'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = banks_open_i ? ST_PRE : ST_REF;
      ST_PRE:  st_d = ST_WRP;
      ST_WRP:  if (wdone) st_d = ST_REF;
      ST_REF:  st_d = ST_WRFC;
      ST_WRFC: if (wdone) st_d = go ? ST_REF : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_PRE:           wcnt_q <= WCW'(T_RP - 1);
        ST_REF:           wcnt_q <= WCW'(T_RFC - 1);
        ST_WRP, ST_WRFC:  if (!wdone) wcnt_q <= wcnt_q - WCW'(1);
        default:          wcnt_q <= wcnt_q;
      endcase
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    a10_o = 1'b0;
    if (st_q == ST_PRE) begin
      cmd_o = CMD_PRE;
      a10_o = 1'b1;
    end else if (st_q == ST_REF) begin
      cmd_o = CMD_REF;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign ref_o  = (st_q == ST_REF);

  // checker-only spacing counters
  logic [15:0] since_pre_q, since_ref_q;
  logic        pre_open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre_q <= '0;
      since_ref_q <= '1;
      pre_open_q  <= 1'b0;
    end else begin
      since_pre_q <= (cmd_o == CMD_PRE) ? 16'd1 :
                     (since_pre_q != '1) ? since_pre_q + 16'd1 : since_pre_q;
      since_ref_q <= (cmd_o == CMD_REF) ? 16'd1 :
                     (since_ref_q != '1) ? since_ref_q + 16'd1 : since_ref_q;
      if (cmd_o == CMD_PRE)      pre_open_q <= 1'b1;
      else if (cmd_o == CMD_REF) pre_open_q <= 1'b0;
    end
  end

  a_r6_rp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && pre_open_q) |-> since_pre_q == 16'(T_RP));
  a_r8_rfc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> since_ref_q >= 16'(T_RFC));
  a_r4_forced_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && urgent_i) |=> busy_o);
  a_r11_no_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !pending_i) |=> !busy_o);
  a_r5_closed_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && go && !banks_open_i) |=> cmd_o == CMD_REF);
  a_r7_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> since_ref_q == 16'(T_RFC));

endmodule

// File: rtl/ddr2_refresh_sched.sv
module ddr2_refresh_sched
  import refsched_pkg::*;
#(
  parameter int TCK_PS   = 2500,
  parameter int TREFI_PS = 7_812_500,
  parameter int TRP_PS   = 15_000,
  parameter int TRFC_PS  = 75_000,
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic banks_open_i,
  input  logic grant_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic a10_o,
  output logic cke_o
);
  localparam int REFI_CYC = TREFI_PS / TCK_PS;
  localparam int HOT_CYC  = (REFI_CYC / 2 < 1) ? 1 : REFI_CYC / 2;
  localparam int RP_RAW   = (TRP_PS + TCK_PS - 1) / TCK_PS;
  localparam int RFC_RAW  = (TRFC_PS + TCK_PS - 1) / TCK_PS;
  localparam int RP_CYC   = (RP_RAW < 2) ? 2 : RP_RAW;
  localparam int RFC_CYC  = (RFC_RAW < 2) ? 2 : RFC_RAW;

  logic     tick, pending, urgent, ref_issued;
  ddr_cmd_t cmd;

  refsched_tick #(.LIM_NORM(REFI_CYC), .LIM_HOT(HOT_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hot_i (hot_i),
    .tick_o(tick)
  );

  refsched_debt #(.MAX_PEND(MAX_PEND)) u_debt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ref_i    (ref_issued),
    .pending_o(pending),
    .urgent_o (urgent)
  );

  refsched_seq #(.T_RP(RP_CYC), .T_RFC(RFC_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending),
    .urgent_i    (urgent),
    .grant_i     (grant_i),
    .banks_open_i(banks_open_i),
    .cmd_o       (cmd),
    .a10_o       (a10_o),
    .busy_o      (busy_o),
    .ref_o       (ref_issued)
  );

  assign req_o    = pending;
  assign urgent_o = urgent;
  assign ras_n_o  = cmd.ras_n;
  assign cas_n_o  = cmd.cas_n;
  assign we_n_o   = cmd.we_n;
  assign cke_o    = 1'b1;  // power-down is handled elsewhere

  a_r10_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_NOP) || (cmd == CMD_PRE) || (cmd == CMD_REF));
  a_r7_cmd_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP) |-> busy_o);
  a_r9_req_after_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ref_issued));

endmodule

// File: tb/sim_ddr2_refresh_sched.sv
module sim_ddr2_refresh_sched;
  localparam int TCK_PS   = 4000;
  localparam int TREFI_PS = 160_000;
  localparam int TRP_PS   = 12_000;
  localparam int TRFC_PS  = 40_000;
  localparam int MAX_PEND = 8;

  function automatic int cyc_ceil(int ps);
    int c;
    c = (ps + TCK_PS - 1) / TCK_PS;
    return (c < 2) ? 2 : c;
  endfunction
  function automatic int refi_cyc(bit hot);
    return hot ? (TREFI_PS / TCK_PS) / 2 : TREFI_PS / TCK_PS;
  endfunction

  localparam logic [2:0] E_NOP = 3'b111;
  localparam logic [2:0] E_PRE = 3'b010;
  localparam logic [2:0] E_REF = 3'b001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hot_i = 1'b0, banks_open_i = 1'b0, grant_i = 1'b0;
  logic req_o, urgent_o, busy_o, ras_n_o, cas_n_o, we_n_o, a10_o, cke_o;
  logic [2:0] cmd;

  int total = 0, bad = 0;
  bit done = 0;
  bit mon_en = 0;
  int e_rp, e_rfc;

  always #2 clk = ~clk;
  assign cmd = {ras_n_o, cas_n_o, we_n_o};

  ddr2_refresh_sched #(
    .TCK_PS(TCK_PS), .TREFI_PS(TREFI_PS), .TRP_PS(TRP_PS),
    .TRFC_PS(TRFC_PS), .MAX_PEND(MAX_PEND)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hot_i(hot_i), .banks_open_i(banks_open_i),
    .grant_i(grant_i), .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .a10_o(a10_o),
    .cke_o(cke_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    mon_en = 0;
    rst_ni = 1'b0;
    step(3);
    rst_ni = 1'b1;
    mon_en = 1;
  endtask

  // protocol monitor
  int since_pre = 0, since_ref = 1000;
  bit pre_open = 0, urg_idle = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      since_pre = 0; since_ref = 1000; pre_open = 0; urg_idle = 0;
    end else begin
      since_pre++; since_ref++;
      chk(cke_o == 1'b1, "R10 cke", cke_o, 1);
      if (urg_idle) chk(busy_o == 1'b1, "R4 forced start", busy_o, 1);
      if (cmd == E_PRE) begin
        chk(a10_o == 1'b1, "R5 a10 on PRE", a10_o, 1);
        since_pre = 0; pre_open = 1;
      end else if (cmd == E_REF) begin
        if (pre_open) chk(since_pre == e_rp, "R6 PRE->REF", since_pre, e_rp);
        chk(since_ref >= e_rfc, "R8 REF spacing", since_ref, e_rfc);
        since_ref = 0; pre_open = 0;
      end else begin
        chk(cmd == E_NOP && a10_o == 1'b0, "R10 idle NOP", {a10_o, cmd}, {1'b0, E_NOP});
      end
      urg_idle = urgent_o && !busy_o;
    end
  end

  initial begin
    int lim, hlim;
    e_rp  = cyc_ceil(TRP_PS);
    e_rfc = cyc_ceil(TRFC_PS);
    lim   = refi_cyc(1'b0);
    hlim  = refi_cyc(1'b1);

    // R1 reset state
    step(2);
    chk(cmd == E_NOP, "R1 cmd", cmd, E_NOP);
    chk(a10_o == 0 && cke_o == 1, "R1 a10/cke", {a10_o, cke_o}, 2'b01);
    chk({req_o, urgent_o, busy_o} == 3'b000, "R1 flags", {req_o, urgent_o, busy_o}, 0);

    // normal interval, saturation, forced start with open banks
    do_reset();
    step(lim - 1);
    chk(req_o == 0, "R2 before interval", req_o, 0);
    step(1);
    chk(req_o == 1, "R2 at interval", req_o, 1);
    step(MAX_PEND * lim - lim - 1);
    chk(urgent_o == 0, "R4 not yet urgent", urgent_o, 0);
    banks_open_i = 1'b1;
    step(1);
    chk(urgent_o == 1, "R4 urgent at limit", urgent_o, 1);
    chk(cmd == E_NOP && busy_o == 0, "R4 still idle", {busy_o, cmd}, {1'b0, E_NOP});
    step(1);
    chk(cmd == E_PRE && a10_o == 1, "R5 PRE all", {a10_o, cmd}, {1'b1, E_PRE});
    chk(busy_o == 1, "R7 busy at start", busy_o, 1);
    step(e_rp - 1);
    chk(cmd == E_NOP, "R6 wait tRP", cmd, E_NOP);
    step(1);
    chk(cmd == E_REF, "R6 REF after tRP", cmd, E_REF);
    banks_open_i = 1'b0;
    step(e_rfc - 1);
    chk(busy_o == 1, "R7 busy during tRFC", busy_o, 1);
    chk(urgent_o == 0, "R9 count dropped", urgent_o, 0);
    step(1);
    chk(busy_o == 0, "R7 busy released", busy_o, 0);
    grant_i = 1'b1;
    step(1);
    chk(cmd == E_REF, "R5 direct REF closed banks", cmd, E_REF);
    step(e_rfc - 1);
    chk(cmd == E_NOP && busy_o == 1, "R8 gap", {busy_o, cmd}, {1'b1, E_NOP});
    step(1);
    chk(cmd == E_REF, "R8 back-to-back REF", cmd, E_REF);
    grant_i = 1'b0;
    step(e_rfc);
    chk(busy_o == 0, "R7 release after burst", busy_o, 0);

    // hot interval, grant ignored without request, drain
    hot_i = 1'b1;
    grant_i = 1'b1;
    do_reset();
    step(hlim - 1);
    chk(req_o == 0 && busy_o == 0, "R11 grant ignored", {req_o, busy_o}, 0);
    chk(cmd == E_NOP, "R11 bus NOP", cmd, E_NOP);
    step(1);
    chk(req_o == 1, "R3 hot interval", req_o, 1);
    step(1);
    chk(cmd == E_REF, "R5 granted REF", cmd, E_REF);
    step(1);
    chk(req_o == 0, "R9 req falls", req_o, 0);
    grant_i = 1'b0;
    step(e_rfc);
    chk(busy_o == 0, "R7 idle again", busy_o, 0);

    // random traffic under the monitor
    hot_i = 1'b0;
    do_reset();
    void'($urandom(32'd2718));
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) hot_i = $urandom_range(0, 1);
      grant_i      = ($urandom_range(0, 3) == 0);
      banks_open_i = $urandom_range(0, 1);
      step(1);
    end
    grant_i = 1'b0;
    step(e_rfc + e_rp + 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule